// File: doc/BRIEF.md
# DDR4 Power-Up Initialization Sequencer

This block is the controller-side state machine that takes one DDR4 memory channel from reset up to the point where its mode registers are loaded. After a start pulse it checks whether a port and a DIMM are present. If either is missing it finishes at once. Otherwise it programs the command engine's mode outputs and puts the memory interface pins into their entry state. It then starts the memory clock pair, releases the DRAM reset, raises CKE and holds it, and finally switches the command-engine address path away.

Every interval is counted in controller clock cycles. The counts come from nanosecond figures and the clock-period parameter, rounded up. One down-counter, reloaded on entry to each timed state, provides all of the waits. After the address path is switched, the sequencer hands three load phases to an external command engine, strictly in order. Each phase uses a one-hot request that is held until the engine returns a done pulse, which carries an error bit. An error stops the sequence.

States, in order:

- S_IDLE goes to S_CFG on start when a port and a DIMM are present. Otherwise it goes to S_FINISH.
- S_CFG goes to S_CLK_STABLE.
- S_CLK_STABLE goes to S_RST_WAIT when its count expires.
- S_RST_WAIT goes to S_CKE_HOLD when its count expires.
- S_CKE_HOLD goes to S_MUX_OFF when its count expires.
- S_MUX_OFF goes to S_LOAD.
- S_LOAD goes to S_FINISH after the last phase completes cleanly. It goes to S_ABORT when the engine reports an error.
- S_FINISH and S_ABORT go back to S_IDLE.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: A start with port_present_i=0 or dimm_present_i=0 gives a one-cycle done_o in the cycle after start, with err_o=0. No pin or mode output changes its value.
- R2: In the cycle after an accepted start, the following hold: dram_rst_n_o=0, dram_rst_en_o=0, addr_mux_sel_o=1, cke_o=0, mclk_drive_o=0 and busy_o=1. The four engine mode outputs read stop_on_err=0, ue_disable=0, cke_copy=1 and parity_after=1.
- R3: One cycle after that, mclk_drive_o=1, mclk_t_o=2'b10 and mclk_c_o=2'b01. This happens while reset is still asserted.
- R4: dram_rst_n_o and dram_rst_en_o rise together exactly STABLE_CYC cycles after the clocks start. STABLE_CYC = max(ceil(T_CLK_STABLE_NS*1000/CLK_PERIOD_PS), CLK_STABLE_MIN).
- R5: cke_o rises exactly ceil(T_RESET_WAIT_NS*1000/CLK_PERIOD_PS) cycles after reset release.
- R6: addr_mux_sel_o falls exactly CKE_HOLD_CYC cycles after cke_o rises. No phase request is active at that point.
- R7: The first phase request rises one cycle after the mux falls. ph_req_o is one-hot: bit0 is register control words, bit1 is data-buffer control words and bit2 is mode registers. A request is held until ph_done_i. On a clean done, the next request appears in the following cycle.
- R8: ph_done_i with ph_err_i=1 clears all requests in the next cycle, pulses done_o with err_o=1, and starts no further phase. err_o stays set until the next start.
- R9: A clean done on the mode-register phase pulses done_o for one cycle with err_o=0, and busy_o falls in that same cycle.
- R10: start_i while busy_o=1 is ignored, and the timing in progress is not disturbed.
- R11: Synchronous rst_i returns the block to idle with the following values: dram_rst_n_o=0, dram_rst_en_o=0, cke_o=0, addr_mux_sel_o=1, clocks undriven at 2'b00, mode outputs 0, and ph_req_o, busy_o and done_o all 0.
- R12: busy_o is high from the cycle after an accepted start until the cycle done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin the sequence (sampled in idle only) |
| port_present_i | input | 1 | A memory port is present |
| dimm_present_i | input | 1 | At least one DIMM is populated |
| ph_done_i | input | 1 | Command engine finished the requested phase |
| ph_err_i | input | 1 | Error qualifier for ph_done_i |
| ph_req_o | output | 3 | One-hot load phase request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last sequence aborted on a phase error |
| dram_rst_n_o | output | 1 | DRAM reset, active low |
| dram_rst_en_o | output | 1 | DRAM reset enable |
| cke_o | output | 1 | Clock enable |
| mclk_drive_o | output | 1 | Memory clock pair driven |
| mclk_t_o | output | 2 | True clock static pattern |
| mclk_c_o | output | 2 | Complement clock static pattern |
| addr_mux_sel_o | output | 1 | Command-engine address mux select |
| eng_stop_on_err_o | output | 1 | Engine mode: stop on error |
| eng_ue_dis_o | output | 1 | Engine mode: uncorrectable-error disable |
| eng_cke_copy_o | output | 1 | Engine mode: copy CKE to spare CKE |
| eng_par_after_o | output | 1 | Engine mode: parity after command |

## Verification
Most results are due one edge after their cause. The entry state, the done pulse of an empty channel, the next phase request, and the abort or finish pulse all appear in the cycle after the input that caused them. The first request comes one cycle after the mux falls. The three timed edges are each checked for an exact cycle distance from the previous edge: STABLE_CYC, then the rounded-up reset wait, then CKE_HOLD_CYC. The bench drives inputs and samples outputs on the falling clock edge. It advances one cycle at a time and counts cycles between observed edges, so every comparison lands in the exact cycle where the result is due.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CFG,
        S_CLK_STABLE,
        S_RST_WAIT,
        S_CKE_HOLD,
        S_MUX_OFF,
        S_LOAD,
        S_FINISH,
        S_ABORT
    } seq_state_e;

    localparam int NUM_PHASES = 3;
    localparam int PH_RCW     = 0;
    localparam int PH_BCW     = 1;
    localparam int PH_MRS     = 2;

    localparam logic [1:0] MCLK_T_INIT = 2'b10;
    localparam logic [1:0] MCLK_C_INIT = 2'b01;

    function automatic longint unsigned ns_to_cyc(longint unsigned ns,
                                                  longint unsigned period_ps);
        return (ns * 64'd1000 + period_ps - 64'd1) / period_ps;
    endfunction

    function automatic longint unsigned max_u(longint unsigned a, longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_pwrup_timer.sv
module ddr_pwrup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R4 R5 R6: each wait shrinks by exactly one per cycle
    a_r4_count_down: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r5_load_taken: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/ddr_pwrup_phase_ctrl.sv
module ddr_pwrup_phase_ctrl #(
    parameter int NUM = 3
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           launch_i,
    input  logic           done_i,
    input  logic           err_i,
    output logic [NUM-1:0] req_o,
    output logic           all_ok_o,
    output logic           fail_o
);

    logic [NUM-1:0] req_q;
    logic [NUM-1:0] req_d;
    logic           active;
    logic           advance;

    assign active  = |req_q;
    assign advance = done_i && active && !err_i;

    for (genvar g = 0; g < NUM; g++) begin : g_bit
        if (g == 0) begin : g_first
            always_comb begin
                if (launch_i)              req_d[g] = 1'b1;
                else if (done_i && active) req_d[g] = 1'b0;
                else                       req_d[g] = req_q[g];
            end
        end else begin : g_rest
            always_comb begin
                if (launch_i)     req_d[g] = 1'b0;
                else if (advance) req_d[g] = req_q[g-1];
                else if (done_i && active) req_d[g] = 1'b0;
                else              req_d[g] = req_q[g];
            end

            // R7: a clean done moves the request up by one phase
            a_r7_phase_order: assert property (@(posedge clk_i) disable iff (rst_i)
                (advance && req_q[g-1]) |=> req_q[g]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) req_q <= '0;
        else       req_q <= req_d;
    end

    assign req_o    = req_q;
    assign all_ok_o = advance && req_q[NUM-1];
    assign fail_o   = done_i && active && err_i;

    a_r7_req_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(req_q));

    // R8: an error clears every request
    a_r8_fail_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        fail_o |=> (req_q == '0));

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_pwrup_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS   = 1250,
    parameter int unsigned T_CLK_STABLE_NS = 10,
    parameter int unsigned CLK_STABLE_MIN  = 5,
    parameter int unsigned T_RESET_WAIT_NS = 500000,
    parameter int unsigned CKE_HOLD_CYC    = 400
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic       port_present_i,
    input  logic       dimm_present_i,
    input  logic       ph_done_i,
    input  logic       ph_err_i,
    output logic [2:0] ph_req_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic       dram_rst_n_o,
    output logic       dram_rst_en_o,
    output logic       cke_o,
    output logic       mclk_drive_o,
    output logic [1:0] mclk_t_o,
    output logic [1:0] mclk_c_o,
    output logic       addr_mux_sel_o,
    output logic       eng_stop_on_err_o,
    output logic       eng_ue_dis_o,
    output logic       eng_cke_copy_o,
    output logic       eng_par_after_o
);

    localparam longint unsigned STABLE_CYC =
        max_u(ns_to_cyc(T_CLK_STABLE_NS, CLK_PERIOD_PS), CLK_STABLE_MIN);
    localparam longint unsigned RST_WAIT_CYC = ns_to_cyc(T_RESET_WAIT_NS, CLK_PERIOD_PS);
    localparam longint unsigned HOLD_CYC     = max_u(CKE_HOLD_CYC, 1);
    localparam longint unsigned CNT_MAX      = max_u(max_u(STABLE_CYC, RST_WAIT_CYC), HOLD_CYC);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] LD_STABLE = CNT_W'(STABLE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RST    = CNT_W'(max_u(RST_WAIT_CYC, 1) - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);

    seq_state_e       state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             ph_launch;
    logic             ph_all_ok;
    logic             ph_fail;
    logic             start_ok;

    assign start_ok  = start_i && port_present_i && dimm_present_i;
    assign ph_launch = (state_q == S_MUX_OFF);

    ddr_pwrup_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    ddr_pwrup_phase_ctrl #(.NUM(NUM_PHASES)) u_phase (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .launch_i (ph_launch),
        .done_i   (ph_done_i),
        .err_i    (ph_err_i),
        .req_o    (ph_req_o),
        .all_ok_o (ph_all_ok),
        .fail_o   (ph_fail)
    );

    // Next-state and timer reload
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = start_ok ? S_CFG : S_FINISH;
            end
            S_CFG: begin
                state_d  = S_CLK_STABLE;
                tmr_load = 1'b1;
                tmr_val  = LD_STABLE;
            end
            S_CLK_STABLE: begin
                if (tmr_zero) begin
                    state_d  = S_RST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RST;
                end
            end
            S_RST_WAIT: begin
                if (tmr_zero) begin
                    state_d  = S_CKE_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            S_CKE_HOLD: begin
                if (tmr_zero) state_d = S_MUX_OFF;
            end
            S_MUX_OFF: state_d = S_LOAD;
            S_LOAD: begin
                if (ph_fail)        state_d = S_ABORT;
                else if (ph_all_ok) state_d = S_FINISH;
            end
            S_FINISH: state_d = S_IDLE;
            S_ABORT:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= S_IDLE;
        else       state_q <= state_d;
    end

    // Registered outputs, updated on state entry
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_o            <= 1'b0;
            err_o             <= 1'b0;
            dram_rst_n_o      <= 1'b0;
            dram_rst_en_o     <= 1'b0;
            cke_o             <= 1'b0;
            mclk_drive_o      <= 1'b0;
            mclk_t_o          <= 2'b00;
            mclk_c_o          <= 2'b00;
            addr_mux_sel_o    <= 1'b1;
            eng_stop_on_err_o <= 1'b0;
            eng_ue_dis_o      <= 1'b0;
            eng_cke_copy_o    <= 1'b0;
            eng_par_after_o   <= 1'b0;
        end else begin
            done_o <= (state_d == S_FINISH) || (state_d == S_ABORT);
            if (state_q == S_IDLE && start_i) err_o <= 1'b0;
            if (state_q != state_d) begin
                unique case (state_d)
                    S_CFG: begin
                        eng_stop_on_err_o <= 1'b0;
                        eng_ue_dis_o      <= 1'b0;
                        eng_cke_copy_o    <= 1'b1;
                        eng_par_after_o   <= 1'b1;
                        dram_rst_n_o      <= 1'b0;
                        dram_rst_en_o     <= 1'b0;
                        addr_mux_sel_o    <= 1'b1;
                        cke_o             <= 1'b0;
                        mclk_drive_o      <= 1'b0;
                        mclk_t_o          <= 2'b00;
                        mclk_c_o          <= 2'b00;
                    end
                    S_CLK_STABLE: begin
                        mclk_drive_o <= 1'b1;
                        mclk_t_o     <= MCLK_T_INIT;
                        mclk_c_o     <= MCLK_C_INIT;
                    end
                    S_RST_WAIT: begin
                        dram_rst_n_o  <= 1'b1;
                        dram_rst_en_o <= 1'b1;
                    end
                    S_CKE_HOLD: cke_o <= 1'b1;
                    S_MUX_OFF:  addr_mux_sel_o <= 1'b0;
                    S_ABORT:    err_o <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign busy_o = !(state_q inside {S_IDLE, S_FINISH, S_ABORT});

    // R3: reset is released only while the clocks are driven
    a_r3_clk_before_rst: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(dram_rst_n_o) |-> (mclk_drive_o && mclk_t_o == MCLK_T_INIT
                                  && mclk_c_o == MCLK_C_INIT));

    // R5: CKE rises only after reset release, with the mux still on the engine
    a_r5_cke_after_rst: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(cke_o) |-> (dram_rst_n_o && dram_rst_en_o && addr_mux_sel_o));

    // R6: mux switches only with CKE high and no phase pending
    a_r6_mux_after_cke: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(addr_mux_sel_o) |-> (cke_o && ph_req_o == 3'b000));

    // R7: no load phase while the address mux still selects the engine path
    a_r7_req_mux_low: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_req_o != 3'b000) |-> !addr_mux_sel_o);

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    // R12: done and busy never overlap
    a_r12_busy_done: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !busy_o);

    // R2: engine mode holds its programmed value throughout a run
    a_r2_mode_set: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> (!eng_stop_on_err_o && !eng_ue_dis_o && eng_cke_copy_o && eng_par_after_o));

endmodule

// File: tb/ddr_pwrup_seq_tb.sv
module ddr_pwrup_seq_tb;

    localparam int unsigned PERIOD_PS = 20000;
    localparam int unsigned RST_NS    = 2010;
    localparam int unsigned STAB_NS   = 10;
    localparam int unsigned STAB_MIN  = 5;
    localparam int unsigned HOLD      = 400;

    // Expected counts, worked from the requirement formulas
    localparam int EXP_STAB_RAW = (STAB_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int EXP_STABLE   = (EXP_STAB_RAW > STAB_MIN) ? EXP_STAB_RAW : STAB_MIN;
    localparam int EXP_RST      = (RST_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;

    // {port, dimm, err_phase[1:0]} ; err_phase 3 = no error
    localparam logic [3:0] VEC [0:6] = '{
        4'b1111, 4'b0111, 4'b1100, 4'b1011, 4'b1101, 4'b0011, 4'b1110
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       port_p = 1'b0;
    logic       dimm_p = 1'b0;
    logic       ph_done = 1'b0;
    logic       ph_err = 1'b0;
    logic [2:0] ph_req;
    logic       busy, done, err;
    logic       rst_n, rst_en, cke, mdrv, mux;
    logic [1:0] mt, mc;
    logic       m_soe, m_ued, m_cc, m_pa;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ddr_pwrup_seq #(
        .CLK_PERIOD_PS   (PERIOD_PS),
        .T_CLK_STABLE_NS (STAB_NS),
        .CLK_STABLE_MIN  (STAB_MIN),
        .T_RESET_WAIT_NS (RST_NS),
        .CKE_HOLD_CYC    (HOLD)
    ) u_dut (
        .clk_i (clk), .rst_i (rst), .start_i (start),
        .port_present_i (port_p), .dimm_present_i (dimm_p),
        .ph_done_i (ph_done), .ph_err_i (ph_err), .ph_req_o (ph_req),
        .busy_o (busy), .done_o (done), .err_o (err),
        .dram_rst_n_o (rst_n), .dram_rst_en_o (rst_en), .cke_o (cke),
        .mclk_drive_o (mdrv), .mclk_t_o (mt), .mclk_c_o (mc),
        .addr_mux_sel_o (mux),
        .eng_stop_on_err_o (m_soe), .eng_ue_dis_o (m_ued),
        .eng_cke_copy_o (m_cc), .eng_par_after_o (m_pa)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [11:0] pins();
        return {rst_n, rst_en, cke, mdrv, mt, mc, mux, m_soe, m_ued, m_cc};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic run_vec(logic [3:0] v);
        logic [11:0] snap;
        int n;
        port_p = v[3];
        dimm_p = v[2];
        snap = pins();
        start = 1'b1;
        step();
        start = 1'b0;
        if (!(v[3] && v[2])) begin
            chk("R1", "done pulse", done, 1);
            chk("R1", "err", err, 0);
            chk("R1", "pins unchanged", int'(pins() == snap), 1);
            chk("R12", "busy empty", busy, 0);
            step();
            chk("R1", "done drop", done, 0);
            return;
        end
        chk("R2", "rst_n", rst_n, 0);
        chk("R2", "rst_en", rst_en, 0);
        chk("R2", "mux", mux, 1);
        chk("R2", "cke", cke, 0);
        chk("R2", "clk undriven", mdrv, 0);
        chk("R2", "modes", {m_soe, m_ued, m_cc, m_pa}, 4'b0011);
        chk("R12", "busy", busy, 1);
        chk("R2", "err cleared", err, 0);
        step();
        chk("R3", "clk drive", mdrv, 1);
        chk("R3", "clk t", mt, 2'b10);
        chk("R3", "clk c", mc, 2'b01);
        chk("R3", "rst still low", rst_n, 0);
        n = 0;
        while (!rst_n && n < 5000) begin step(); n++; end
        chk("R4", "stable cycles", n, EXP_STABLE);
        chk("R4", "rst_en with rst_n", rst_en, 1);
        n = 0;
        while (!cke && n < 5000) begin
            if (n == 10) start = 1'b1;
            if (n == 11) begin
                start = 1'b0;
                chk("R10", "start ignored rst_n", rst_n, 1);
                chk("R10", "start ignored busy", busy, 1);
            end
            step();
            n++;
        end
        chk("R5", "reset wait cycles", n, EXP_RST);
        chk("R5", "mux high at cke", mux, 1);
        n = 0;
        while (mux && n < 5000) begin step(); n++; end
        chk("R6", "cke hold cycles", n, HOLD);
        chk("R6", "no req at mux fall", ph_req, 0);
        step();
        for (int p = 0; p < 3; p++) begin
            chk("R7", "req onehot", ph_req, 3'b001 << p);
            step(); step();
            chk("R7", "req held", ph_req, 3'b001 << p);
            ph_done = 1'b1;
            ph_err  = (v[1:0] == 2'(p));
            step();
            ph_done = 1'b0;
            ph_err  = 1'b0;
            if (v[1:0] == 2'(p)) begin
                chk("R8", "req cleared", ph_req, 0);
                chk("R8", "done pulse", done, 1);
                chk("R8", "err set", err, 1);
                step();
                ph_done = 1'b1;
                step();
                ph_done = 1'b0;
                step();
                chk("R8", "no further phase", ph_req, 0);
                chk("R8", "err sticky", err, 1);
                chk("R8", "done single", done, 0);
                return;
            end
        end
        chk("R9", "done pulse", done, 1);
        chk("R9", "err clear", err, 0);
        chk("R9", "busy falls", busy, 0);
        chk("R9", "req idle", ph_req, 0);
        step();
        chk("R9", "done drop", done, 0);
    endtask

    initial begin
        repeat (3) step();
        chk("R11", "rst_n", rst_n, 0);
        chk("R11", "mux", mux, 1);
        chk("R11", "busy", busy, 0);
        rst = 1'b0;
        step();
        for (int i = 0; i < 7; i++) run_vec(VEC[i]);

        // Synchronous reset in the middle of a run
        port_p = 1'b1;
        dimm_p = 1'b1;
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (20) step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R11", "rst_n low", rst_n, 0);
        chk("R11", "rst_en low", rst_en, 0);
        chk("R11", "cke low", cke, 0);
        chk("R11", "mux high", mux, 1);
        chk("R11", "clk undriven", {mdrv, mt, mc}, 0);
        chk("R11", "modes cleared", {m_soe, m_ued, m_cc, m_pa}, 0);
        chk("R11", "busy", busy, 0);
        chk("R11", "done", done, 0);
        chk("R11", "req", ph_req, 0);
        step();
        chk("R11", "stays idle", busy, 0);
        run_vec(4'b1111);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule